// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the sixteen 32-bit general registers of a processor core whose upper registers change with the processor mode. A 5-bit mode value, together with a one-cycle change strobe, selects which copy of the upper registers is live. The fast-interrupt mode has private copies of registers 8 to 14. Each other privileged mode has private copies of registers 13 and 14 only. Registers 0 to 7 and register 15 are shared by every mode. Register 15 is an ordinary storage location here.

The core reads the live file through two combinational read ports and writes it through one synchronous write port. A separate debug port reads or writes any register as seen from any named mode, without switching modes. On a mode-change cycle the whole save/restore happens at that single clock edge. A core write in the same cycle lands in the new mode's view. A debug write in the same cycle is resolved against the old mode.

Mode values that name no bank select a dummy bank. Entering the dummy bank zeroes live registers 8 to 14. The dummy bank stores nothing.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-low reset clears every live and banked register to zero and sets the current mode to the RESET_MODE parameter (default 0x13, supervisor).
- R2: Read ports A and B return the live register named by their address in the same cycle. A write with wr_en high is visible on the read ports from the next cycle.
- R3: Mode-to-bank map: 0x00/0x10 and 0x1F are user; 0x01/0x11 are fast-interrupt; 0x02/0x12 are interrupt; 0x03/0x13 are supervisor; 0x17 is abort; 0x1B is undefined. Every other value is the dummy bank.
- R4: A mode change between two modes of the same bank (for example 0x13 to 0x03, or 0x1F to 0x10) leaves every live register unchanged.
- R5: Registers 0 to 7 and 15 are never swapped by a mode change.
- R6: On a change between two non-fast banks, the live registers 13 and 14 are saved to the old bank's slots and reloaded from the new bank's slots. Registers 8 to 12 stay live.
- R7: Entering the fast-interrupt bank from a non-fast bank saves live 8 to 12 as the shared copies and loads 8 to 14 from the fast slots. Leaving it saves live 8 to 14 into the fast slots and restores 8 to 12 from the shared copies.
- R8: Entering the dummy bank forces live 8 to 14 to zero. Leaving it restores only what R6/R7 restore, so 8 to 12 stay zero.
- R9: A debug access naming a mode whose bank is the current bank reads or writes the live registers.
- R10: A debug access naming another mode reaches that mode's banked copy. For registers 0 to 7 and 15 it reaches the live register. For the dummy bank, registers 8 to 14 read zero and writes to them are dropped.
- R11: A core write in a mode-change cycle is applied after the swap, into the new mode's live view.
- R12: A debug write in a mode-change cycle is resolved against the old mode and applied before the swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_in | input | 5 | Mode to switch to when mode_chg is high |
| mode_chg | input | 1 | Mode-change strobe |
| ra_addr | input | 4 | Read port A register index |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 4 | Read port B register index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Core write enable |
| wr_addr | input | 4 | Core write register index |
| wr_data | input | 32 | Core write data |
| dbg_mode | input | 5 | Mode whose view the debug port accesses |
| dbg_addr | input | 4 | Debug register index |
| dbg_wen | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |

## Verification
The bench builds the block with DATA_W = 32 and RESET_MODE = 0x13. Starting in supervisor mode, the first mode changes leave the supervisor bank, so the save path for a bank other than user is exercised from the first swap onward. At full width, values that differ in their upper bits show that whole words are moved. The vector walk visits every named bank, a same-bank alias in both the supervisor and user/system groups, and the dummy bank. It then lets the debug port inspect the slots left behind, including the fast-interrupt copies and the shared user copies that exist only while the fast bank is live.

// File: rtl/rbank_pkg.sv
// Package: shared constants, types and the mode-to-bank decode for the
// banked register file. Assumes a 5-bit mode field and 16 architectural registers.
package rbank_pkg;
    localparam int NUM_ARCH   = 16;
    localparam int ADDR_W     = $clog2(NUM_ARCH);
    localparam int MODE_W     = 5;
    localparam int SHR_LO     = 8;              // first register banked by fast mode
    localparam int SHR_CNT    = 5;              // registers 8..12
    localparam int SLOT_BANKS = 6;              // banks owning a 13/14 pair

    typedef logic [ADDR_W-1:0] ridx_t;
    typedef logic [MODE_W-1:0] mode_t;

    // Bank codes double as the index into the 13/14 slot array.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5,
        BK_DUM = 3'd6
    } bank_e;

    // Storage reached by a debug access.
    typedef enum logic [2:0] {
        TG_LIVE, TG_SHARED, TG_FIQ, TG_SLOT, TG_NONE
    } tgt_e;

    // Map a mode value to its bank; unknown values land in the dummy bank.
    function automatic bank_e mode_bank(input mode_t m);
        case (m)
            5'h00, 5'h10, 5'h1F: mode_bank = BK_USR;
            5'h01, 5'h11:        mode_bank = BK_FIQ;
            5'h02, 5'h12:        mode_bank = BK_IRQ;
            5'h03, 5'h13:        mode_bank = BK_SVC;
            5'h17:               mode_bank = BK_ABT;
            5'h1B:               mode_bank = BK_UND;
            default:             mode_bank = BK_DUM;
        endcase
    endfunction

    // True for banks that keep only a private 13/14 pair.
    function automatic logic is_plain(input bank_e b);
        is_plain = (b != BK_FIQ) && (b != BK_DUM);
    endfunction
endpackage

// File: rtl/rbank_swap.sv
// Module: rbank_swap
// Combinational save/restore network for one mode change. Given the state
// before the swap and the old/new banks, it produces the state after the swap.
// Assumes the caller applies it only on the mode-change cycle (en).
module rbank_swap
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                                  en,
    input  bank_e                                 old_bank,
    input  bank_e                                 new_bank,
    input  logic [NUM_ARCH-1:0][DATA_W-1:0]       live_i,
    input  logic [SHR_CNT-1:0][DATA_W-1:0]        hi_i,
    input  logic [SHR_CNT-1:0][DATA_W-1:0]        fq_i,
    input  logic [SLOT_BANKS-1:0][1:0][DATA_W-1:0] slot_i,
    output logic [NUM_ARCH-1:0][DATA_W-1:0]       live_o,
    output logic [SHR_CNT-1:0][DATA_W-1:0]        hi_o,
    output logic [SHR_CNT-1:0][DATA_W-1:0]        fq_o,
    output logic [SLOT_BANKS-1:0][1:0][DATA_W-1:0] slot_o
);
    localparam int SHR_HI = SHR_LO + SHR_CNT - 1;   // 12
    localparam int PAIR_LO = SHR_HI + 1;            // 13
    localparam int PAIR_HI = PAIR_LO + 1;           // 14

    // Save the outgoing view, then load the incoming one.
    always_comb begin
        live_o = live_i;
        hi_o   = hi_i;
        fq_o   = fq_i;
        slot_o = slot_i;
        if (en && (old_bank != new_bank)) begin
            case (old_bank)
                BK_FIQ: begin
                    fq_o           = live_i[SHR_HI:SHR_LO];
                    slot_o[BK_FIQ] = live_i[PAIR_HI:PAIR_LO];
                end
                BK_DUM: ;
                default: begin
                    slot_o[old_bank] = live_i[PAIR_HI:PAIR_LO];
                    if (new_bank == BK_FIQ)
                        hi_o = live_i[SHR_HI:SHR_LO];
                end
            endcase
            case (new_bank)
                BK_FIQ: begin
                    live_o[SHR_HI:SHR_LO]   = fq_i;
                    live_o[PAIR_HI:PAIR_LO] = slot_i[BK_FIQ];
                end
                BK_DUM: live_o[PAIR_HI:SHR_LO] = '0;
                default: begin
                    if (old_bank == BK_FIQ)
                        live_o[SHR_HI:SHR_LO] = hi_i;
                    live_o[PAIR_HI:PAIR_LO] = slot_i[new_bank];
                end
            endcase
        end
    end
endmodule

// File: rtl/rbank_dbg.sv
// Module: rbank_dbg
// Resolves a debug access into the storage it reaches and returns read data.
// Assumes both banks come from rbank_pkg::mode_bank.
module rbank_dbg
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bank_e                                  cur_bank,
    input  bank_e                                  dbg_bank,
    input  ridx_t                                  addr,
    input  logic [NUM_ARCH-1:0][DATA_W-1:0]        live,
    input  logic [SHR_CNT-1:0][DATA_W-1:0]         hi,
    input  logic [SHR_CNT-1:0][DATA_W-1:0]         fq,
    input  logic [SLOT_BANKS-1:0][1:0][DATA_W-1:0] slot,
    output tgt_e                                   tgt,
    output logic [DATA_W-1:0]                      rdata
);
    localparam ridx_t LO_IDX   = ridx_t'(SHR_LO);
    localparam ridx_t PAIR_IDX = ridx_t'(SHR_LO + SHR_CNT);
    localparam ridx_t PC_IDX   = ridx_t'(NUM_ARCH - 1);

    logic [2:0] sidx;
    logic       pair_sel;

    assign sidx     = 3'(addr - LO_IDX);
    assign pair_sel = (addr != PAIR_IDX);   // 0: r13, 1: r14

    // Pick the storage the access reaches.
    always_comb begin
        if (dbg_bank == cur_bank || addr < LO_IDX || addr == PC_IDX)
            tgt = TG_LIVE;
        else if (dbg_bank == BK_DUM)
            tgt = TG_NONE;
        else if (addr >= PAIR_IDX)
            tgt = TG_SLOT;
        else if (dbg_bank == BK_FIQ)
            tgt = TG_FIQ;
        else if (cur_bank == BK_FIQ)
            tgt = TG_SHARED;
        else
            tgt = TG_LIVE;
    end

    // Return the word from the chosen storage.
    always_comb begin
        case (tgt)
            TG_LIVE:   rdata = live[addr];
            TG_SHARED: rdata = hi[sidx];
            TG_FIQ:    rdata = fq[sidx];
            TG_SLOT:   rdata = slot[dbg_bank][pair_sel];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/rbank_rdport.sv
// Module: rbank_rdport
// One combinational read port on the live register file.
module rbank_rdport
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_ARCH-1:0][DATA_W-1:0] live,
    input  ridx_t                           addr,
    output logic [DATA_W-1:0]               data
);
    // Select the addressed live register.
    assign data = live[addr];
endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile
// Sixteen-entry register file with mode-banked upper registers, two core
// read ports, one core write port and a debug port into any mode's view.
// Update order within a cycle: debug write (old mode), bank swap, core write.
// Assumes mode_chg is a one-cycle strobe qualified by mode_in.
module banked_regfile
    import rbank_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [4:0]  RESET_MODE = 5'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_in,
    input  logic              mode_chg,
    input  logic [3:0]        ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [3:0]        rb_addr,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [4:0]        dbg_mode,
    input  logic [3:0]        dbg_addr,
    input  logic              dbg_wen,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata
);
    localparam int    NUM_RD   = 2;
    localparam ridx_t LO_IDX   = ridx_t'(SHR_LO);
    localparam ridx_t PAIR_IDX = ridx_t'(SHR_LO + SHR_CNT);

    logic [NUM_ARCH-1:0][DATA_W-1:0]        live_q, live_a, live_b, live_n;
    logic [SHR_CNT-1:0][DATA_W-1:0]         hi_q, hi_a, hi_n;
    logic [SHR_CNT-1:0][DATA_W-1:0]         fq_q, fq_a, fq_n;
    logic [SLOT_BANKS-1:0][1:0][DATA_W-1:0] slot_q, slot_a, slot_n;
    mode_t cur_mode_q;
    bank_e cur_bank, new_bank, dbg_bank;
    tgt_e  dbg_tgt;

    logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    assign cur_bank = mode_bank(cur_mode_q);
    assign new_bank = mode_bank(mode_in);
    assign dbg_bank = mode_bank(dbg_mode);

    // Core read ports, one instance per port.
    assign rd_addr = {rb_addr, ra_addr};
    generate
        for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
            rbank_rdport #(.DATA_W(DATA_W)) u_rd (
                .live (live_q),
                .addr (rd_addr[g]),
                .data (rd_data[g])
            );
        end
    endgenerate
    assign ra_data = rd_data[0];
    assign rb_data = rd_data[1];

    // Debug routing and read data.
    rbank_dbg #(.DATA_W(DATA_W)) u_dbg (
        .cur_bank (cur_bank),
        .dbg_bank (dbg_bank),
        .addr     (dbg_addr),
        .live     (live_q),
        .hi       (hi_q),
        .fq       (fq_q),
        .slot     (slot_q),
        .tgt      (dbg_tgt),
        .rdata    (dbg_rdata)
    );

    // Step 1: apply a debug write against the pre-change mode.
    always_comb begin
        live_a = live_q;
        hi_a   = hi_q;
        fq_a   = fq_q;
        slot_a = slot_q;
        if (dbg_wen) begin
            case (dbg_tgt)
                TG_LIVE:   live_a[dbg_addr] = dbg_wdata;
                TG_SHARED: hi_a[3'(dbg_addr - LO_IDX)] = dbg_wdata;
                TG_FIQ:    fq_a[3'(dbg_addr - LO_IDX)] = dbg_wdata;
                TG_SLOT:   slot_a[dbg_bank][dbg_addr != PAIR_IDX] = dbg_wdata;
                default: ;
            endcase
        end
    end

    // Step 2: bank swap on a mode change.
    rbank_swap #(.DATA_W(DATA_W)) u_swap (
        .en       (mode_chg),
        .old_bank (cur_bank),
        .new_bank (new_bank),
        .live_i   (live_a),
        .hi_i     (hi_a),
        .fq_i     (fq_a),
        .slot_i   (slot_a),
        .live_o   (live_b),
        .hi_o     (hi_n),
        .fq_o     (fq_n),
        .slot_o   (slot_n)
    );

    // Step 3: core write lands in the post-swap view.
    always_comb begin
        live_n = live_b;
        if (wr_en)
            live_n[wr_addr] = wr_data;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q     <= '0;
            hi_q       <= '0;
            fq_q       <= '0;
            slot_q     <= '0;
            cur_mode_q <= RESET_MODE;
        end else begin
            live_q <= live_n;
            hi_q   <= hi_n;
            fq_q   <= fq_n;
            slot_q <= slot_n;
            if (mode_chg)
                cur_mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/rbank_chk.sv
// Module: rbank_chk
// Property checker for banked_regfile, attached by bind below.
module rbank_chk
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [4:0]                      mode_in,
    input logic                            mode_chg,
    input logic                            wr_en,
    input logic [3:0]                      wr_addr,
    input logic [DATA_W-1:0]               wr_data,
    input logic [4:0]                      dbg_mode,
    input logic [3:0]                      dbg_addr,
    input logic                            dbg_wen,
    input logic [DATA_W-1:0]               dbg_rdata,
    input logic [4:0]                      cur_mode_q,
    input logic [NUM_ARCH-1:0][DATA_W-1:0] live_q,
    input logic [SHR_CNT-1:0][DATA_W-1:0]  hi_q
);
    bank_e cb, nb;
    assign cb = mode_bank(cur_mode_q);
    assign nb = mode_bank(mode_in);

    AST_SAME_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && nb == cb && !wr_en && !dbg_wen) |=> $stable(live_q)); // R4

    AST_UNBANKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !wr_en && !dbg_wen) |=>
            (live_q[7:0] == $past(live_q[7:0]) && live_q[15] == $past(live_q[15]))); // R5

    AST_SHARED_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && nb == BK_FIQ && is_plain(cb) && !dbg_wen) |=>
            (hi_q == $past(live_q[12:8]))); // R7

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && nb == BK_DUM && cb != BK_DUM && !wr_en) |=> (live_q[14:8] == '0)); // R8

    AST_CORE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (live_q[$past(wr_addr)] == $past(wr_data))); // R11

    AST_DBG_LIVE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bank(dbg_mode) == cb) |-> (dbg_rdata == live_q[dbg_addr])); // R9
endmodule

bind banked_regfile rbank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_in    (mode_in),
    .mode_chg   (mode_chg),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dbg_mode   (dbg_mode),
    .dbg_addr   (dbg_addr),
    .dbg_wen    (dbg_wen),
    .dbg_rdata  (dbg_rdata),
    .cur_mode_q (cur_mode_q),
    .live_q     (live_q),
    .hi_q       (hi_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk, rst_n;
    logic [4:0]    mode_in, dbg_mode;
    logic          mode_chg, wr_en, dbg_wen;
    logic [3:0]    ra_addr, rb_addr, wr_addr, dbg_addr;
    logic [DW-1:0] ra_data, rb_data, wr_data, dbg_wdata, dbg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    banked_regfile #(.DATA_W(DW), .RESET_MODE(5'h13)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .mode_chg(mode_chg),
        .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dbg_mode(dbg_mode), .dbg_addr(dbg_addr), .dbg_wen(dbg_wen),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [7:0]  req;
        logic        chg;
        logic [4:0]  mode;
        logic        we;
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  caddr;
        logic [31:0] cexp;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{8'd2,  1'b0, 5'h13, 1'b1, 4'd13, 32'hA000_0013, 4'd13, 32'hA000_0013}, // R2
        '{8'd2,  1'b0, 5'h13, 1'b1, 4'd8,  32'h0000_0088, 4'd8,  32'h0000_0088}, // R2
        '{8'd2,  1'b0, 5'h13, 1'b1, 4'd3,  32'h0000_0033, 4'd3,  32'h0000_0033}, // R2
        '{8'd6,  1'b1, 5'h12, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0},         // R6 into IRQ
        '{8'd2,  1'b0, 5'h12, 1'b1, 4'd13, 32'h1313_0012, 4'd13, 32'h1313_0012}, // R2
        '{8'd6,  1'b1, 5'h13, 1'b0, 4'd0,  32'h0,         4'd13, 32'hA000_0013}, // R6 back to SVC
        '{8'd4,  1'b1, 5'h03, 1'b0, 4'd0,  32'h0,         4'd13, 32'hA000_0013}, // R4 R3 alias
        '{8'd7,  1'b1, 5'h11, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0},         // R7 enter fast
        '{8'd2,  1'b0, 5'h11, 1'b1, 4'd8,  32'h0000_00F8, 4'd8,  32'h0000_00F8}, // R2
        '{8'd7,  1'b1, 5'h10, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_0088}, // R7 shared restore
        '{8'd5,  1'b0, 5'h10, 1'b0, 4'd0,  32'h0,         4'd3,  32'h0000_0033}, // R5
        '{8'd7,  1'b1, 5'h01, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_00F8}, // R7 R3 alias
        '{8'd8,  1'b1, 5'h05, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0},         // R8 R3 unknown
        '{8'd8,  1'b1, 5'h1F, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0},         // R8 leave dummy
        '{8'd2,  1'b0, 5'h1F, 1'b1, 4'd14, 32'h0000_0E14, 4'd14, 32'h0000_0E14}, // R2
        '{8'd4,  1'b1, 5'h10, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_0E14}, // R4 system=user
        '{8'd11, 1'b1, 5'h17, 1'b1, 4'd14, 32'h0000_AB14, 4'd14, 32'h0000_AB14}, // R11
        '{8'd6,  1'b1, 5'h1B, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0},         // R6 undef
        '{8'd6,  1'b1, 5'h17, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_AB14}, // R6 abort
        '{8'd6,  1'b1, 5'h10, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_0E14}, // R6 user
        '{8'd5,  1'b0, 5'h10, 1'b0, 4'd0,  32'h0,         4'd3,  32'h0000_0033}  // R5
    };

    task automatic check(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // One clock with the given core-side stimulus, then strobes drop.
    task automatic step(input logic chg, input logic [4:0] m, input logic we,
                        input logic [3:0] wa, input logic [DW-1:0] wd);
        mode_chg = chg; mode_in = m; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk); #1;
        mode_chg = 1'b0; wr_en = 1'b0; dbg_wen = 1'b0;
    endtask

    task automatic rd_a(input int req, input logic [3:0] a, input logic [DW-1:0] exp,
                        input string what);
        ra_addr = a; #1;
        check(req, ra_data, exp, what);
    endtask

    task automatic dbg_rd(input int req, input logic [4:0] m, input logic [3:0] a,
                          input logic [DW-1:0] exp, input string what);
        dbg_mode = m; dbg_addr = a; #1;
        check(req, dbg_rdata, exp, what);
    endtask

    task automatic dbg_wr(input logic [4:0] m, input logic [3:0] a, input logic [DW-1:0] d);
        dbg_mode = m; dbg_addr = a; dbg_wdata = d; dbg_wen = 1'b1;
        step(1'b0, 5'h00, 1'b0, 4'd0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mode_in = 5'h13; mode_chg = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; ra_addr = '0; rb_addr = '0;
        dbg_mode = 5'h13; dbg_addr = '0; dbg_wen = 1'b0; dbg_wdata = '0;
        do_reset();

        // R1: everything cleared after reset
        rd_a(1, 4'd0, '0, "reset r0");
        rb_addr = 4'd15; #1; check(1, rb_data, '0, "reset r15 port B");
        dbg_rd(1, 5'h12, 4'd13, '0, "reset IRQ r13 slot");

        // Vector walk: stimulus then read-back on port A
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].chg, VECS[i].mode, VECS[i].we, VECS[i].waddr, VECS[i].wdata);
            rd_a(int'(VECS[i].req), VECS[i].caddr, VECS[i].cexp, $sformatf("vector %0d", i));
        end

        // R9: same-bank debug names reach the live file (now in user mode)
        dbg_rd(9, 5'h1F, 4'd14, 32'h0000_0E14, "dbg system r14 live");
        dbg_rd(9, 5'h10, 4'd3, 32'h0000_0033, "dbg user r3 live");
        rb_addr = 4'd3; #1; check(2, rb_data, 32'h0000_0033, "port B r3");

        // R10: other-mode banked copies
        dbg_rd(10, 5'h11, 4'd8, 32'h0000_00F8, "dbg fast r8");
        dbg_rd(10, 5'h13, 4'd13, 32'hA000_0013, "dbg SVC r13");
        dbg_rd(10, 5'h12, 4'd13, 32'h1313_0012, "dbg IRQ r13");
        dbg_rd(10, 5'h07, 4'd13, 32'h0, "dbg dummy r13");

        // R10: debug write into SVC slot leaves live user r14 alone
        dbg_wr(5'h13, 4'd14, 32'h0000_5E14);
        rd_a(10, 4'd14, 32'h0000_0E14, "live r14 after SVC slot write");
        // R10: dummy write dropped
        dbg_wr(5'h09, 4'd13, 32'h0000_DEAD);
        dbg_rd(10, 5'h09, 4'd13, 32'h0, "dummy write dropped");
        rd_a(10, 4'd13, 32'h0, "live r13 after dummy write");
        // R9: debug write naming the current mode lands live
        dbg_wr(5'h10, 4'd5, 32'h0000_0055);
        rd_a(9, 4'd5, 32'h0000_0055, "live r5 after dbg write");

        // R10: slot written by debug appears on entering SVC
        step(1'b1, 5'h13, 1'b0, 4'd0, '0);
        rd_a(10, 4'd14, 32'h0000_5E14, "SVC r14 from debug write");
        step(1'b0, 5'h13, 1'b1, 4'd9, 32'h0000_0099);

        // R12: debug write to SVC r13 in the cycle SVC is left for fast mode
        dbg_mode = 5'h13; dbg_addr = 4'd13; dbg_wdata = 32'h0000_0C13; dbg_wen = 1'b1;
        step(1'b1, 5'h11, 1'b0, 4'd0, '0);
        dbg_rd(12, 5'h13, 4'd13, 32'h0000_0C13, "SVC r13 saved after pre-swap dbg write");
        rd_a(12, 4'd13, 32'h0, "fast r13 live");

        // R7: shared copy of r9 visible through debug; fast r9 is live
        dbg_rd(7, 5'h10, 4'd9, 32'h0000_0099, "shared user r9");
        rd_a(7, 4'd9, 32'h0, "fast r9 live");

        // R1: second reset clears slots and live file
        do_reset();
        rd_a(1, 4'd5, '0, "r5 after reset");
        dbg_rd(1, 5'h12, 4'd13, '0, "IRQ slot after reset");
        dbg_rd(1, 5'h11, 4'd8, '0, "fast r8 after reset");

        finish_run();
    end
endmodule